// File: doc/BRIEF.md
# Serial Control Word Receiver with Audio Path Decode

This block receives one 8-bit control word over a three-wire serial port (data, serial clock and an active-high frame enable) and turns the stored word into the digital controls of an audio routing and volume stage. All three serial pins are brought into the system clock domain through two-flop synchronizers. Serial clock and enable edges are found on the synchronized copies. The system clock must run at least four times faster than the fastest serial clock.

A transfer opens when the enable rises. Bits are taken on serial clock rises, least significant first. The word is committed only when the enable falls after all eight bits have arrived. A frame that closes early leaves the previous settings in place. Clock rises after the eighth are ignored. The committed word is decoded combinationally into these outputs:
- a shutdown flag;
- speaker enable and speaker mute;
- two headphone routing selects;
- two signed gain values in half-decibel units.

Top module: `serial_ctl_rx`

## Requirements
- R1: After reset the committed word is 0x00. This means shutdown is 1, all path enables and the speaker mute are 0, the line gain is -69 and the headset gain is -81.
- R2: Bits are shifted in least significant first. The first bit of a frame lands in bit 0 of the committed word and the eighth lands in bit 7.
- R3: Data is sampled only on a serial clock rise while the enable is high. Serial clock pulses while the enable is low leave every output unchanged.
- R4: The outputs change only when the enable falls after at least 8 captured bits. While a frame is in progress they keep the previous word.
- R5: If the enable falls with fewer than 8 bits captured, the frame is dropped and all outputs keep their prior values.
- R6: Serial clock rises after the eighth within one frame are ignored, so the committed word holds the first 8 bits.
- R7: The mode field is bits 2:0. Mode 0 asserts shutdown, and shutdown is then the only flag set.
- R8: Mode bit 0 enables the speaker path. Speaker mute is 1 exactly when the mode is non-zero and bit 0 is clear.
- R9: Mode bit 1 drives the headset-to-headphone route and mode bit 2 drives the line-to-headphone route. Both may be set at once, which means the two sources are summed.
- R10: The volume code is bits 7:3. Line gain is -69 + 3*code in 0.5 dB units, which spans -69 at code 0 to +24 at code 31.
- R11: Headset gain always equals line gain minus 12, in 0.5 dB units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data pin |
| ser_clk | input | 1 | Serial clock pin |
| ser_en | input | 1 | Active-high frame enable pin |
| cfg_word | output | 8 | Last committed control word |
| shutdown | output | 1 | All outputs powered down (mode 0) |
| spk_on | output | 1 | Speaker path enabled |
| spk_mute | output | 1 | Speaker path muted |
| phone_route | output | 1 | Headset input routed to headphones |
| line_route | output | 1 | Line inputs routed to headphones |
| line_gain | output | 8 | Signed line gain, 0.5 dB units |
| phone_gain | output | 8 | Signed headset gain, 0.5 dB units |

## Verification
The assertions rely on three assumptions about the serial pins:
- every level of the serial clock and the enable is held for more than one system clock;
- a serial clock edge and an enable edge never fall in the same system cycle;
- data is steady across each serial clock rise.

The bench meets these by changing pins only on the falling system edge. It holds every serial level for four system cycles, sets data while the serial clock is low, and gives the enable its own quiet cycles before and after each frame.

// File: rtl/serial_ctl_rx.sv
module serial_ctl_rx #(
  parameter int WORD_W    = 8,
  parameter int MODE_W    = 3,
  parameter int GAIN_W    = 8,
  parameter int SYNC_N    = 2,
  parameter int GAIN_BASE = -69,
  parameter int GAIN_STEP = 3,
  parameter int PHONE_OFS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_data,
  input  logic              ser_clk,
  input  logic              ser_en,
  output logic [WORD_W-1:0] cfg_word,
  output logic              shutdown,
  output logic              spk_on,
  output logic              spk_mute,
  output logic              phone_route,
  output logic              line_route,
  output logic [GAIN_W-1:0] line_gain,
  output logic [GAIN_W-1:0] phone_gain
);
  localparam int VOL_W = WORD_W - MODE_W;
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [SYNC_N-1:0] d_sy, c_sy, e_sy;
  logic              c_prev, e_prev;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  nbits;

  wire sd     = d_sy[SYNC_N-1];
  wire sc     = c_sy[SYNC_N-1];
  wire se     = e_sy[SYNC_N-1];
  wire c_rise = sc & ~c_prev;
  wire e_rise = se & ~e_prev;
  wire e_fall = ~se & e_prev;
  wire full   = (nbits == CNT_W'(WORD_W));
  wire take   = se & c_rise & ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_sy   <= '0;
      c_sy   <= '0;
      e_sy   <= '0;
      c_prev <= 1'b0;
      e_prev <= 1'b0;
    end else begin
      d_sy   <= {d_sy[SYNC_N-2:0], ser_data};
      c_sy   <= {c_sy[SYNC_N-2:0], ser_clk};
      e_sy   <= {e_sy[SYNC_N-2:0], ser_en};
      c_prev <= sc;
      e_prev <= se;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      nbits <= '0;
    end else if (e_rise || !se) begin
      nbits <= '0;
    end else if (take) begin
      shreg <= {sd, shreg[WORD_W-1:1]};
      nbits <= nbits + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg_word <= '0;
    else if (e_fall && full)
      cfg_word <= shreg;
  end

  wire [MODE_W-1:0] mode = cfg_word[MODE_W-1:0];
  wire [VOL_W-1:0]  vol  = cfg_word[WORD_W-1:MODE_W];

  assign shutdown    = (mode == '0);
  assign spk_on      = mode[0];
  assign spk_mute    = !shutdown && !mode[0];
  assign phone_route = mode[1];
  assign line_route  = mode[2];
  assign line_gain   = GAIN_W'(GAIN_BASE + GAIN_STEP * int'(vol));
  assign phone_gain  = GAIN_W'(GAIN_BASE + GAIN_STEP * int'(vol) - PHONE_OFS);

  // R4
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(e_fall && full) |=> $stable(cfg_word));
  // R6
  shift_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (se && full && !e_rise) |=> $stable(shreg));
  // R6
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nbits <= CNT_W'(WORD_W));
  // R7
  shutdown_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> !spk_on && !spk_mute && !phone_route && !line_route);
  // R8
  mute_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(spk_mute && spk_on));
  // R10
  gain_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $signed(line_gain) >= GAIN_W'(GAIN_BASE) &&
    $signed(line_gain) <= GAIN_W'(GAIN_BASE + GAIN_STEP * ((1 << VOL_W) - 1)));
  // R11
  gain_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $signed(line_gain) - $signed(phone_gain) == PHONE_OFS);
endmodule

// File: tb/serial_ctl_rx_bench.sv
module serial_ctl_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_en = 1'b0;
  logic [7:0] cfg_word, line_gain, phone_gain;
  logic shutdown, spk_on, spk_mute, phone_route, line_route;
  int errors = 0, checks = 0;
  logic [7:0] cur;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_ctl_rx u_serial_ctl_rx (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_en(ser_en), .cfg_word(cfg_word), .shutdown(shutdown),
    .spk_on(spk_on), .spk_mute(spk_mute), .phone_route(phone_route),
    .line_route(line_route), .line_gain(line_gain), .phone_gain(phone_gain)
  );

  localparam int NV = 10;
  localparam logic [7:0] VEC [NV] = '{8'hFF, 8'h01, 8'h02, 8'h04, 8'h06,
                                      8'h07, 8'h05, 8'h03, 8'hB8, 8'h00};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] bits, input int n);
    ser_en = 1'b1; wait_n(4);
    for (int i = 0; i < n; i++) begin
      ser_data = bits[i]; ser_clk = 1'b0; wait_n(4);
      ser_clk = 1'b1; wait_n(4);
    end
    ser_clk = 1'b0; wait_n(4);
    ser_en = 1'b0; wait_n(8);
  endtask

  task automatic check_all(input string tag, input logic [7:0] w);
    int lg;
    lg = -69 + 3 * int'(w[7:3]);
    chk({tag, " R2 word"}, int'(cfg_word), int'(w));
    chk({tag, " R7 shutdown"}, int'(shutdown), int'(w[2:0] == 3'd0));
    chk({tag, " R8 spk_on"}, int'(spk_on), int'(w[0]));
    chk({tag, " R8 spk_mute"}, int'(spk_mute), int'(w[2:0] != 3'd0 && !w[0]));
    chk({tag, " R9 phone_route"}, int'(phone_route), int'(w[1]));
    chk({tag, " R9 line_route"}, int'(line_route), int'(w[2]));
    chk({tag, " R10 line_gain"}, int'($signed(line_gain)), lg);
    chk({tag, " R11 phone_gain"}, int'($signed(phone_gain)), lg - 12);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    check_all("R1 reset", 8'h00);

    for (int v = 0; v < NV; v++) begin
      send({8'h00, VEC[v]}, 8);
      check_all("R4 vector", VEC[v]);
    end

    send({8'h00, 8'h39}, 8);
    check_all("R2 lsb-first", 8'h39);
    cur = 8'h39;

    // R4: mid-frame outputs keep the old word
    ser_en = 1'b1; wait_n(4);
    for (int i = 0; i < 6; i++) begin
      ser_data = 1'b0; ser_clk = 1'b0; wait_n(4);
      ser_clk = 1'b1; wait_n(4);
    end
    chk("R4 mid-frame hold", int'(cfg_word), int'(cur));
    ser_clk = 1'b0; wait_n(4);
    ser_en = 1'b0; wait_n(8);
    check_all("R5 short frame", cur);

    send({11'h000, 5'h1F}, 5);
    check_all("R5 short frame 5b", cur);

    // R3: clock pulses while enable is low
    for (int i = 0; i < 10; i++) begin
      ser_data = 1'b1; ser_clk = 1'b0; wait_n(4);
      ser_clk = 1'b1; wait_n(4);
    end
    ser_clk = 1'b0; wait_n(8);
    check_all("R3 enable low", cur);

    send({6'h3F, 2'b11, 8'hC6}, 16);
    check_all("R6 extra bits", 8'hC6);

    send({8'hFF, 8'h0A}, 12);
    check_all("R6 extra bits 2", 8'h0A);

    send({8'h00, 8'hF8}, 8);
    check_all("R10 max code", 8'hF8);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); end
    join_any
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule